// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block translates a 32-bit virtual address into a 32-bit physical address. It walks a page table in memory that is up to three levels deep and sits below a per-context root table. A pulse on `start` captures the virtual address, the context table base and the context number. The walker then reads one descriptor at a time over a simple request/acknowledge read port. It never has more than one read outstanding.

Each descriptor read is decoded from its two low type bits. A table pointer sends the walk one level deeper. A leaf entry ends the walk with success, and the leaf may sit at context, region, segment or page level. Any other outcome ends the walk with a fault. When the walk ends, `done` pulses for one cycle. With it come the fault code, the step at which the walk stopped, the leaf's level code, the leaf descriptor, and the physical address. The physical address joins the leaf's page-number bits with as many low virtual-address bits as the leaf's level leaves untranslated.

Top module: `ptw_walker`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are low and `fault` is 000.
- R2: The first read goes to the context table. Its address is `ctx_tbl_ptr*16 + ctx_num*4`, truncated to 32 bits.
- R3: Each later read follows a table pointer, whose pointer field is descriptor bits 31:2. The read address is `pointer*16 + index*4`, truncated to 32 bits. The index is vaddr[31:24] for step 1, vaddr[23:18] for step 2 and vaddr[17:12] for step 3.
- R4: While a read is waiting, `mem_req` stays high and `mem_addr` stays constant until a cycle in which `mem_ack` is high.
- R5: A descriptor of type 10 (leaf) ends the walk with fault 000. `leaf_pte` holds the whole descriptor. `leaf_lvl` reads 11 if the leaf was read at step 0, 10 at step 1, 01 at step 2 and 00 at step 3.
- R6: On success, `paddr` depends on the step at which the leaf was read:
  - step 0: `vaddr` unchanged;
  - step 1: {pte[27:20], vaddr[23:0]};
  - step 2: {pte[27:14], vaddr[17:0]};
  - step 3: {pte[27:8], vaddr[11:0]}.
- R7: A descriptor of type 00 (invalid) ends the walk with fault 001. `fault_lvl` gives the step at which the walk stopped: 0 for the context entry, 1 to 3 for the table levels.
- R8: A descriptor of type 11 (reserved) ends the walk with fault 110 and the step in `fault_lvl`.
- R9: A read acknowledged with `mem_err` high ends the walk with fault 101 and the step in `fault_lvl`.
- R10: A table pointer read at step 3 ends the walk with fault 100 and `fault_lvl` 3.
- R11: `done` is high for exactly one cycle, and in that cycle `busy` and `mem_req` are already low. The results hold until the next walk ends. On any fault, `paddr` and `leaf_pte` are zero.
- R12: `start` has no effect while `busy` is high. The walk in progress keeps its addresses and its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk; taken only when idle |
| vaddr | input | 32 | Virtual address to translate |
| ctx_tbl_ptr | input | 30 | Context table base, in units of 16 bytes |
| ctx_num | input | CTX_W | Context number |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Descriptor read request |
| mem_addr | output | 32 | Descriptor byte address |
| mem_ack | input | 1 | Read completes this cycle |
| mem_err | input | 1 | Completed read had a bus error |
| mem_rdata | input | 32 | Descriptor read data |
| done | output | 1 | One-cycle end-of-walk pulse |
| fault | output | 3 | 000 ok, 001 invalid, 100 pointer at last level, 101 bus error, 110 reserved type |
| fault_lvl | output | 2 | Step at which the walk stopped |
| leaf_lvl | output | 2 | Level code of the leaf (11 context ... 00 page) |
| leaf_pte | output | 32 | Leaf descriptor, zero on fault |
| paddr | output | 32 | Translated physical address, zero on fault |

## Verification
The hardest cases to reach are the deep ones: a pointer found after the last level, and a reserved type or a bus error at step 3. Each needs three correctly chained pointer descriptors before the final read. The bench acts as the memory and builds each pointer from the virtual address and the step. It therefore knows every address the walker must produce and can end the walk at any chosen step with any chosen outcome. Every combination of end step and outcome is swept across several addresses. Response latencies vary, and `start` is pulsed with a different address during waits.

// File: rtl/ptw_walker.sv
module ptw_walker #(
  parameter int CTX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      vaddr,
  input  logic [29:0]      ctx_tbl_ptr,
  input  logic [CTX_W-1:0] ctx_num,
  output logic             busy,
  output logic             mem_req,
  output logic [31:0]      mem_addr,
  input  logic             mem_ack,
  input  logic             mem_err,
  input  logic [31:0]      mem_rdata,
  output logic             done,
  output logic [2:0]       fault,
  output logic [1:0]       fault_lvl,
  output logic [1:0]       leaf_lvl,
  output logic [31:0]      leaf_pte,
  output logic [31:0]      paddr
);
  localparam logic [1:0] TY_INV = 2'b00;
  localparam logic [1:0] TY_PTR = 2'b01;
  localparam logic [1:0] TY_LEAF = 2'b10;
  localparam logic [2:0] F_OK  = 3'b000;
  localparam logic [2:0] F_INV = 3'b001;
  localparam logic [2:0] F_PTR = 3'b100;
  localparam logic [2:0] F_BUS = 3'b101;
  localparam logic [2:0] F_RSV = 3'b110;

  logic        busy_q, done_q;
  logic [1:0]  step_q;
  logic [31:0] va_q, addr_q;
  logic [2:0]  fault_q;
  logic [1:0]  flvl_q, llvl_q;
  logic [31:0] pte_q, pa_q;

  logic [7:0]  idx;
  logic [31:0] ctx_addr, ptr_addr, merged;
  logic        finish, descend;
  logic [2:0]  fcode;

  assign busy      = busy_q;
  assign mem_req   = busy_q;
  assign mem_addr  = addr_q;
  assign done      = done_q;
  assign fault     = fault_q;
  assign fault_lvl = flvl_q;
  assign leaf_lvl  = llvl_q;
  assign leaf_pte  = pte_q;
  assign paddr     = pa_q;

  assign ctx_addr = 32'({ctx_tbl_ptr, 4'b0000}) + 32'({ctx_num, 2'b00});
  assign ptr_addr = {mem_rdata[29:2], 4'b0000} + {22'd0, idx, 2'b00};

  always_comb begin
    case (step_q)
      2'd0:    idx = va_q[31:24];
      2'd1:    idx = {2'b00, va_q[23:18]};
      default: idx = {2'b00, va_q[17:12]};
    endcase
  end

  always_comb begin
    case (step_q)
      2'd0:    merged = va_q;
      2'd1:    merged = {mem_rdata[27:20], va_q[23:0]};
      2'd2:    merged = {mem_rdata[27:14], va_q[17:0]};
      default: merged = {mem_rdata[27:8], va_q[11:0]};
    endcase
  end

  always_comb begin
    finish  = 1'b0;
    descend = 1'b0;
    fcode   = F_OK;
    if (busy_q && mem_ack) begin
      if (mem_err) begin
        finish = 1'b1;
        fcode  = F_BUS;
      end else begin
        case (mem_rdata[1:0])
          TY_LEAF: finish = 1'b1;
          TY_PTR: begin
            if (step_q == 2'd3) begin
              finish = 1'b1;
              fcode  = F_PTR;
            end else begin
              descend = 1'b1;
            end
          end
          TY_INV: begin
            finish = 1'b1;
            fcode  = F_INV;
          end
          default: begin
            finish = 1'b1;
            fcode  = F_RSV;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      step_q  <= 2'd0;
      va_q    <= '0;
      addr_q  <= '0;
      fault_q <= F_OK;
      flvl_q  <= 2'd0;
      llvl_q  <= 2'd0;
      pte_q   <= '0;
      pa_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          step_q <= 2'd0;
          va_q   <= vaddr;
          addr_q <= ctx_addr;
        end
      end else if (finish) begin
        busy_q  <= 1'b0;
        done_q  <= 1'b1;
        fault_q <= fcode;
        flvl_q  <= step_q;
        llvl_q  <= ~step_q;
        pte_q   <= (fcode == F_OK) ? mem_rdata : 32'd0;
        pa_q    <= (fcode == F_OK) ? merged : 32'd0;
      end else if (descend) begin
        step_q <= step_q + 2'd1;
        addr_q <= ptr_addr;
      end
    end
  end
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_ack,
  input logic        done,
  input logic [2:0]  fault,
  input logic [31:0] leaf_pte,
  input logic [31:0] paddr
);
  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !mem_req));

  p_fault_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault != 3'b000) |-> (paddr == 32'd0 && leaf_pte == 32'd0));

  p_leaf_type_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault == 3'b000) |-> (leaf_pte[1:0] == 2'b10));

  p_fault_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault inside {3'b000, 3'b001, 3'b100, 3'b101, 3'b110}));

  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);
endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_req(mem_req),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .done(done), .fault(fault),
  .leaf_pte(leaf_pte), .paddr(paddr)
);

// File: tb/ptw_walker_bench.sv
module ptw_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] vaddr = '0;
  logic [29:0] ctx_tbl_ptr = '0;
  logic [7:0]  ctx_num = '0;
  logic        busy, mem_req, done;
  logic [31:0] mem_addr, leaf_pte, paddr;
  logic        mem_ack = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic [2:0]  fault;
  logic [1:0]  fault_lvl, leaf_lvl;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ptw_walker u_ptw_walker (
    .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr),
    .ctx_tbl_ptr(ctx_tbl_ptr), .ctx_num(ctx_num), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .done(done), .fault(fault),
    .fault_lvl(fault_lvl), .leaf_lvl(leaf_lvl), .leaf_pte(leaf_pte),
    .paddr(paddr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] index_of(input logic [31:0] va, input int s);
    if (s == 1) return (va >> 24) & 32'hFF;
    if (s == 2) return (va >> 18) & 32'h3F;
    return (va >> 12) & 32'h3F;
  endfunction

  // kind: 0 leaf, 1 invalid, 2 reserved, 3 bus error, 4 pointer at step 3
  task automatic walk(input logic [31:0] va, input logic [29:0] ctp, input logic [7:0] cn,
                      input int last, input int kind, input logic [31:0] leafv, input bit poke);
    logic [31:0] exp_addr, d, mask, exp_pa;
    logic [29:0] ptr;
    logic [2:0]  exp_f;
    @(negedge clk);
    vaddr = va; ctx_tbl_ptr = ctp; ctx_num = cn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    exp_addr = (32'(ctp) << 4) + (32'(cn) << 2);
    for (int s = 0; s <= last; s++) begin
      check(mem_req === 1'b1, (s == 0) ? "R2" : "R3", 32'(mem_req), 32'd1);
      check(mem_addr === exp_addr, (s == 0) ? "R2" : "R3", mem_addr, exp_addr);
      for (int w = 0; w < (s + int'(va[0]) + int'(cn[1])) % 3; w++) begin
        if (poke) begin
          vaddr = ~va; ctx_tbl_ptr = ~ctp; ctx_num = ~cn; start = 1'b1;
        end
        @(negedge clk);
        start = 1'b0;
        check(mem_req === 1'b1 && mem_addr === exp_addr, poke ? "R12" : "R4", mem_addr, exp_addr);
      end
      mem_err = 1'b0;
      if (s < last) begin
        ptr = 30'(32'h0123_4567 * (s + 3) ^ va ^ {cn, 24'd0});
        d = {ptr, 2'b01};
        exp_addr = (32'(ptr) << 4) + (index_of(va, s + 1) << 2);
      end else begin
        case (kind)
          0: d = {leafv[31:2], 2'b10};
          1: d = {leafv[31:2], 2'b00};
          2: d = {leafv[31:2], 2'b11};
          3: begin d = {leafv[31:2], 2'b10}; mem_err = 1'b1; end
          default: d = {leafv[31:2], 2'b01};
        endcase
      end
      mem_ack = 1'b1; mem_rdata = d;
      @(posedge clk);
      #1 mem_ack = 1'b0; mem_err = 1'b0;
      @(negedge clk);
    end
    case (kind)
      0: exp_f = 3'b000;
      1: exp_f = 3'b001;
      2: exp_f = 3'b110;
      3: exp_f = 3'b101;
      default: exp_f = 3'b100;
    endcase
    check(done === 1'b1 && busy === 1'b0, "R11", {30'd0, done, busy}, 32'd2);
    case (kind)
      0: check(fault === exp_f, "R5", 32'(fault), 32'(exp_f));
      1: check(fault === exp_f, "R7", 32'(fault), 32'(exp_f));
      2: check(fault === exp_f, "R8", 32'(fault), 32'(exp_f));
      3: check(fault === exp_f, "R9", 32'(fault), 32'(exp_f));
      default: check(fault === exp_f, "R10", 32'(fault), 32'(exp_f));
    endcase
    if (kind == 0) begin
      mask = (last == 0) ? 32'hFFFF_FFFF : ((32'd1 << (12 + 6 * (3 - last) + ((last == 1) ? 0 : 0))) - 32'd1);
      if (last == 1) mask = 32'h00FF_FFFF;
      if (last == 2) mask = 32'h0003_FFFF;
      if (last == 3) mask = 32'h0000_0FFF;
      exp_pa = ((d << 4) & ~mask) | (va & mask);
      check(leaf_lvl === 2'(3 - last), "R5", 32'(leaf_lvl), 32'(3 - last));
      check(leaf_pte === d, "R5", leaf_pte, d);
      check(paddr === exp_pa, "R6", paddr, exp_pa);
    end else begin
      check(fault_lvl === 2'(last), "R7", 32'(fault_lvl), 32'(last));
      check(paddr === 32'd0 && leaf_pte === 32'd0, "R11", paddr | leaf_pte, 32'd0);
    end
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R11", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] vas [3];
    vas[0] = 32'hA5C3_7E19;
    vas[1] = 32'h0000_0FFF;
    vas[2] = 32'hFFFF_F000;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0, "R1", {29'd0, busy, done, mem_req}, 32'd0);
    check(fault === 3'b000, "R1", 32'(fault), 32'd0);
    rst_n = 1'b1;
    for (int v = 0; v < 3; v++) begin
      for (int last = 0; last < 4; last++) begin
        for (int kind = 0; kind < 4; kind++) begin
          walk(vas[v], 30'(32'h0ABC_D000 + v * 32'h111 + last), 8'(v * 85 + kind),
               last, kind, 32'h9E37_79B9 ^ (vas[v] >> last) ^ 32'(kind), v == 1);
        end
      end
      // R10: pointer found at the last level
      walk(vas[v], 30'(32'h1357_9BDF + v), 8'(255 - v), 3, 4, 32'hCAFE_F00D, v == 2);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule